// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block sits behind the pins of a double-data-rate SDRAM model or in front of a memory controller's command path. On every rising clock edge it samples clock enable, chip select, the three strobe pins, the bank select and the address bus. It turns that pin pattern into a single decoded command and checks the command against the state of the bank it targets. It also keeps an idle or active state and an open-row register for every bank.

Decoded commands appear one cycle after sampling, as a one-hot strobe. Alongside the strobe come the captured bank, row and column, the auto-precharge request of the latest column access, and the choice between the main and the extended mode register. A command that breaks a bank rule is refused: the block raises an illegal flag and leaves its state untouched. Clock-enable transitions move the block into and out of self refresh and the two power-down flavours. While the block is in one of those states, every other input is ignored.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With CKE high in the previous and current cycle and CS# high, the block reports deselect (strobe bit 0). No bank state changes.
- R2: CS# low with RAS#, CAS# and WE# all high reports a no-operation (bit 1).
- R3: RAS# low, CAS# high, WE# high to an idle bank reports activate (bit 2). The bank becomes active, and its open row, `row_o` and `bank_o` take A11..A0 and BA.
- R4: RAS# low, CAS# high, WE# low is a precharge, legal in any state. With A8 low it reports bit 3 and idles only the selected bank. With A8 high it reports bit 4 and idles every bank.
- R5: RAS# high with CAS# low to an active bank is a read (WE# high, bit 5) or a write (WE# low, bit 6). `col_o` takes A7..A0 and `auto_pre_o` takes A8. With A8 high the bank returns to idle.
- R6: RAS#, CAS# and WE# all low, with all banks idle and BA1 low, is a mode-register load (bit 7). `ext_mode_o` takes BA0: 0 selects the main register and 1 selects the extended register.
- R7: RAS# and CAS# low with WE# high, with CKE high in both cycles and all banks idle, is auto refresh (bit 8).
- R8: CS# low, RAS# and CAS# high and WE# low is burst stop (bit 13).
- R9: Four cases are illegal: activate to an active bank, read or write to an idle bank, a mode load with a bank active or BA1 high, and refresh with a bank active. Each one sets `illegal_o`, gives an all-zero strobe and leaves the bank state, open rows and low-power state unchanged.
- R10: CKE falling (high before, low now) with the refresh encoding and CS# low, while all banks are idle, reports self-refresh entry (bit 9). `lp_state_o` becomes 3. The first cycle with CKE high afterwards reports self-refresh exit (bit 10) and returns `lp_state_o` to 0.
- R11: Any other CKE fall reports power-down entry (bit 11). `lp_state_o` becomes 1 if a bank is active and 2 if all banks are idle. The first cycle with CKE high reports power-down exit (bit 12) and returns `lp_state_o` to 0.
- R12: The strobe is all zero after reset and never has more than one bit set. After reset all banks are idle, every open row is zero and `lp_state_o` is 0.
- R13: Nothing is decoded, and the strobe stays zero, in four cases: while in a low-power state with CKE low, while awake with CKE low in both cycles, in the wake cycle where CKE was low before and is high now, and after a refused self-refresh entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 12 | Address bus (row, column, A8 flag, op-code) |
| cmd_strobe_o | output | 14 | One-hot decoded command, bit map in R1 to R13 |
| bank_o | output | 2 | Bank of the last accepted activate, precharge or column command |
| row_o | output | 12 | Row of the last accepted activate |
| col_o | output | 8 | Column of the last accepted read or write |
| auto_pre_o | output | 1 | A8 of the last accepted read or write |
| ext_mode_o | output | 1 | BA0 of the last accepted mode load |
| illegal_o | output | 1 | Command refused by a bank-state rule |
| bank_active_o | output | 4 | Per-bank active flag |
| open_rows_o | output | 48 | Open-row registers, bank n at bits n*12 upward |
| lp_state_o | output | 2 | 0 awake, 1 active power-down, 2 precharge power-down, 3 self refresh |

## Verification
The bench builds the block with its defaults: four banks, a 12-bit address, an 8-bit column and A8 as the precharge flag. With only four banks, a random two-bit bank select lands on an already-open or already-closed bank often. That makes the refusal paths of R9 common, rather than rare, in the random phase. A directed prologue walks every command, the BA1 check on mode loads, auto-precharge closing a bank, and each CKE-driven entry and exit. Those include a refused self-refresh entry and the wake cycle that follows it.

// File: rtl/stk_pkg.sv
// Shared types for the SDRAM command tracker.
// Assumes: the command code doubles as the strobe bit index.
package stk_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_PRE   = 4'd3,
        CMD_PREA  = 4'd4,
        CMD_RD    = 4'd5,
        CMD_WR    = 4'd6,
        CMD_MRS   = 4'd7,
        CMD_AREF  = 4'd8,
        CMD_SREN  = 4'd9,
        CMD_SREX  = 4'd10,
        CMD_PDEN  = 4'd11,
        CMD_PDEX  = 4'd12,
        CMD_BST   = 4'd13,
        CMD_NONE  = 4'd15
    } cmd_e;

    localparam int NUM_CMDS = 14;

    typedef enum logic [1:0] {
        LP_AWAKE    = 2'd0,
        LP_ACT_PD   = 2'd1,
        LP_PRE_PD   = 2'd2,
        LP_SELF_REF = 2'd3
    } lp_e;

endpackage

// File: rtl/stk_classify.sv
// Combinational command classifier.
// Maps the CKE pair, the low-power state and the pin pattern to one command.
// Checks legality against the bank state it is given.
// Assumes: bank state inputs reflect the state before this edge.
// A refused command yields CMD_NONE with illegal_o set.
module stk_classify
    import stk_pkg::*;
(
    input  logic cke_i,
    input  logic cke_prev_i,
    input  lp_e  lp_i,
    input  logic cs_n_i,
    input  logic ras_n_i,
    input  logic cas_n_i,
    input  logic we_n_i,
    input  logic ba_hi_zero_i,
    input  logic a8_i,
    input  logic all_idle_i,
    input  logic tgt_active_i,
    output cmd_e cmd_o,
    output logic illegal_o
);

    logic [2:0] rcw;
    assign rcw = {ras_n_i, cas_n_i, we_n_i};

    // Decode one command per edge, qualified by CKE history and bank state.
    always_comb begin
        cmd_o     = CMD_NONE;
        illegal_o = 1'b0;
        if (lp_i != LP_AWAKE) begin
            if (cke_i) begin
                cmd_o = (lp_i == LP_SELF_REF) ? CMD_SREX : CMD_PDEX;
            end
        end else if (cke_prev_i && !cke_i) begin
            if (!cs_n_i && rcw == 3'b001) begin
                if (all_idle_i) cmd_o = CMD_SREN;
                else            illegal_o = 1'b1;
            end else begin
                cmd_o = CMD_PDEN;
            end
        end else if (cke_prev_i && cke_i) begin
            if (cs_n_i) begin
                cmd_o = CMD_DESEL;
            end else begin
                case (rcw)
                    3'b111: cmd_o = CMD_NOP;
                    3'b011: begin
                        if (tgt_active_i) illegal_o = 1'b1;
                        else              cmd_o = CMD_ACT;
                    end
                    3'b010: cmd_o = a8_i ? CMD_PREA : CMD_PRE;
                    3'b101: begin
                        if (tgt_active_i) cmd_o = CMD_RD;
                        else              illegal_o = 1'b1;
                    end
                    3'b100: begin
                        if (tgt_active_i) cmd_o = CMD_WR;
                        else              illegal_o = 1'b1;
                    end
                    3'b000: begin
                        if (all_idle_i && ba_hi_zero_i) cmd_o = CMD_MRS;
                        else                            illegal_o = 1'b1;
                    end
                    3'b001: begin
                        if (all_idle_i) cmd_o = CMD_AREF;
                        else            illegal_o = 1'b1;
                    end
                    3'b110: cmd_o = CMD_BST;
                endcase
            end
        end
    end

endmodule

// File: rtl/stk_bank_table.sv
// Per-bank state and open-row registers.
// Acts only on commands already accepted by the classifier.
// Assumes: cmd_i is CMD_NONE whenever a command was refused.
module stk_bank_table
    import stk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int BA_W      = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  cmd_e                       cmd_i,
    input  logic [BA_W-1:0]            ba_i,
    input  logic [ROW_W-1:0]           row_i,
    input  logic                       ap_i,
    output logic [NUM_BANKS-1:0]       active_o,
    output logic [NUM_BANKS*ROW_W-1:0] rows_o
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (ba_i == BA_W'(b));

        // Track open or closed for bank b.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                active_o[b] <= 1'b0;
            end else if (cmd_i == CMD_PREA) begin
                active_o[b] <= 1'b0;
            end else if (hit) begin
                if (cmd_i == CMD_ACT)
                    active_o[b] <= 1'b1;
                else if (cmd_i == CMD_PRE)
                    active_o[b] <= 1'b0;
                else if ((cmd_i == CMD_RD || cmd_i == CMD_WR) && ap_i)
                    active_o[b] <= 1'b0;
            end
        end

        // Latch the row opened in bank b.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rows_o[b*ROW_W +: ROW_W] <= '0;
            else if (hit && cmd_i == CMD_ACT)
                rows_o[b*ROW_W +: ROW_W] <= row_i;
        end
    end

endmodule

// File: rtl/stk_power_fsm.sv
// Low-power state and CKE history.
// Assumes: entry and exit commands come from the classifier, which saw the same CKE.
module stk_power_fsm
    import stk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke_i,
    input  cmd_e cmd_i,
    input  logic any_active_i,
    output lp_e  lp_o,
    output logic cke_prev_o
);

    // Remember last cycle's CKE; reset treats it as high.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_prev_o <= 1'b1;
        else        cke_prev_o <= cke_i;
    end

    // Move between awake, the two power-down flavours and self refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lp_o <= LP_AWAKE;
        end else begin
            case (cmd_i)
                CMD_SREN: lp_o <= LP_SELF_REF;
                CMD_PDEN: lp_o <= any_active_i ? LP_ACT_PD : LP_PRE_PD;
                CMD_SREX,
                CMD_PDEX: lp_o <= LP_AWAKE;
                default:  lp_o <= lp_o;
            endcase
        end
    end

    assert_lp_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_o != LP_AWAKE && !cke_i) |=> $stable(lp_o));

    assert_lp_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_o != LP_AWAKE && cke_i) |=> (lp_o == LP_AWAKE));

endmodule

// File: rtl/sdram_cmd_tracker.sv
// SDRAM command decoder with per-bank state tracking.
// Registers a one-hot command strobe and the captured address fields one cycle after sampling.
// Assumes: inputs are synchronous to clk.
// Timing of bursts and refresh counting is handled elsewhere.
module sdram_cmd_tracker
    import stk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 8,
    parameter int AP_BIT    = 8,
    parameter int BA_W      = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cke_i,
    input  logic                       cs_n_i,
    input  logic                       ras_n_i,
    input  logic                       cas_n_i,
    input  logic                       we_n_i,
    input  logic [BA_W-1:0]            ba_i,
    input  logic [ROW_W-1:0]           addr_i,
    output logic [NUM_CMDS-1:0]        cmd_strobe_o,
    output logic [BA_W-1:0]            bank_o,
    output logic [ROW_W-1:0]           row_o,
    output logic [COL_W-1:0]           col_o,
    output logic                       auto_pre_o,
    output logic                       ext_mode_o,
    output logic                       illegal_o,
    output logic [NUM_BANKS-1:0]       bank_active_o,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows_o,
    output logic [1:0]                 lp_state_o
);

    cmd_e cmd;
    logic illegal;
    lp_e  lp;
    logic cke_prev;
    logic all_idle;
    logic tgt_active;
    logic ba_hi_zero;

    assign all_idle   = (bank_active_o == '0);
    assign tgt_active = bank_active_o[ba_i];
    assign ba_hi_zero = ((ba_i >> 1) == '0);
    assign lp_state_o = lp;

    stk_classify u_classify (
        .cke_i        (cke_i),
        .cke_prev_i   (cke_prev),
        .lp_i         (lp),
        .cs_n_i       (cs_n_i),
        .ras_n_i      (ras_n_i),
        .cas_n_i      (cas_n_i),
        .we_n_i       (we_n_i),
        .ba_hi_zero_i (ba_hi_zero),
        .a8_i         (addr_i[AP_BIT]),
        .all_idle_i   (all_idle),
        .tgt_active_i (tgt_active),
        .cmd_o        (cmd),
        .illegal_o    (illegal)
    );

    stk_bank_table #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W),
        .BA_W      (BA_W)
    ) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd),
        .ba_i     (ba_i),
        .row_i    (addr_i),
        .ap_i     (addr_i[AP_BIT]),
        .active_o (bank_active_o),
        .rows_o   (open_rows_o)
    );

    stk_power_fsm u_power (
        .clk          (clk),
        .rst_n        (rst_n),
        .cke_i        (cke_i),
        .cmd_i        (cmd),
        .any_active_i (!all_idle),
        .lp_o         (lp),
        .cke_prev_o   (cke_prev)
    );

    // Register the one-hot strobe and the refusal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_strobe_o <= '0;
            illegal_o    <= 1'b0;
        end else begin
            cmd_strobe_o <= '0;
            if (cmd != CMD_NONE)
                cmd_strobe_o[cmd] <= 1'b1;
            illegal_o <= illegal;
        end
    end

    // Capture bank, row, column and mode-select fields of accepted commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_o     <= '0;
            row_o      <= '0;
            col_o      <= '0;
            auto_pre_o <= 1'b0;
            ext_mode_o <= 1'b0;
        end else begin
            case (cmd)
                CMD_ACT: begin
                    bank_o <= ba_i;
                    row_o  <= addr_i;
                end
                CMD_PRE: bank_o <= ba_i;
                CMD_RD, CMD_WR: begin
                    bank_o     <= ba_i;
                    col_o      <= addr_i[COL_W-1:0];
                    auto_pre_o <= addr_i[AP_BIT];
                end
                CMD_MRS: ext_mode_o <= ba_i[0];
                default: ;
            endcase
        end
    end

    assert_strobe_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_strobe_o));

    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (cmd_strobe_o == '0 && $stable(bank_active_o) && $stable(open_rows_o)));

    assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe_o[CMD_ACT] |-> (bank_active_o[bank_o]
                                   && open_rows_o[bank_o*ROW_W +: ROW_W] == row_o));

    assert_prea_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe_o[CMD_PREA] |-> (bank_active_o == '0));

    assert_sref_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe_o[CMD_SREN] |-> (bank_active_o == '0 && lp_state_o == 2'd3));

    assert_mrs_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe_o[CMD_MRS] |-> (bank_active_o == '0));

endmodule

// File: tb/sim_sdram_cmd_tracker.sv
`timescale 1ns/1ps
// Bench with a behavioural reference model, compared on every clock.
module sim_sdram_cmd_tracker;

    localparam int K_DESEL = 0, K_NOP = 1, K_ACT = 2, K_PRE = 3, K_PREA = 4,
                   K_RD = 5, K_WR = 6, K_MRS = 7, K_AREF = 8, K_SREN = 9,
                   K_SREX = 10, K_PDEN = 11, K_PDEX = 12, K_BST = 13, K_NONE = -1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;
    logic [13:0] strobe;
    logic [1:0]  bank;
    logic [11:0] row;
    logic [7:0]  col;
    logic        ap, ext, ill;
    logic [3:0]  act;
    logic [47:0] rows;
    logic [1:0]  lps;

    always #2.5 clk = ~clk;

    sdram_cmd_tracker u0 (
        .clk(clk), .rst_n(rst_n), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
        .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .addr_i(addr),
        .cmd_strobe_o(strobe), .bank_o(bank), .row_o(row), .col_o(col),
        .auto_pre_o(ap), .ext_mode_o(ext), .illegal_o(ill),
        .bank_active_o(act), .open_rows_o(rows), .lp_state_o(lps)
    );

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference model state
    int          m_lp;
    bit          m_ckep;
    bit   [3:0]  m_act;
    logic [11:0] m_rows [4];
    logic [13:0] e_strobe;
    logic [1:0]  e_bank;
    logic [11:0] e_row;
    logic [7:0]  e_col;
    logic        e_ap, e_ext, e_ill;
    string       cur_tag;

    function automatic string tag_of(int k, bit il);
        if (il) return "R9";
        case (k)
            K_DESEL: return "R1";
            K_NOP:   return "R2";
            K_ACT:   return "R3";
            K_PRE, K_PREA: return "R4";
            K_RD, K_WR: return "R5";
            K_MRS:   return "R6";
            K_AREF:  return "R7";
            K_BST:   return "R8";
            K_SREN, K_SREX: return "R10";
            K_PDEN, K_PDEX: return "R11";
            default: return "R13";
        endcase
    endfunction

    task automatic model_reset();
        m_lp = 0; m_ckep = 1'b1; m_act = '0;
        foreach (m_rows[i]) m_rows[i] = '0;
        e_strobe = '0; e_bank = '0; e_row = '0; e_col = '0;
        e_ap = 1'b0; e_ext = 1'b0; e_ill = 1'b0;
        cur_tag = "R12";
    endtask

    // Predict the outputs after the coming edge from the pins now driven.
    task automatic model_step();
        int  k;
        bit  il;
        bit  idle;
        k = K_NONE; il = 1'b0; idle = (m_act == 4'b0);
        if (m_lp != 0) begin
            if (cke) begin
                k = (m_lp == 3) ? K_SREX : K_PDEX;
                m_lp = 0;
            end
        end else if (m_ckep && !cke) begin
            if (!cs_n && !ras_n && !cas_n && we_n) begin
                if (idle) begin k = K_SREN; m_lp = 3; end
                else il = 1'b1;
            end else begin
                k = K_PDEN;
                m_lp = idle ? 2 : 1;
            end
        end else if (m_ckep && cke) begin
            if (cs_n) k = K_DESEL;
            else if (ras_n && cas_n && we_n) k = K_NOP;
            else if (ras_n && cas_n && !we_n) k = K_BST;
            else if (!ras_n && cas_n && we_n) begin
                if (m_act[ba]) il = 1'b1;
                else begin k = K_ACT; m_act[ba] = 1'b1; m_rows[ba] = addr; e_row = addr; e_bank = ba; end
            end else if (!ras_n && cas_n && !we_n) begin
                if (addr[8]) begin k = K_PREA; m_act = '0; end
                else begin k = K_PRE; m_act[ba] = 1'b0; e_bank = ba; end
            end else if (ras_n && !cas_n) begin
                if (!m_act[ba]) il = 1'b1;
                else begin
                    k = we_n ? K_RD : K_WR;
                    e_bank = ba; e_col = addr[7:0]; e_ap = addr[8];
                    if (addr[8]) m_act[ba] = 1'b0;
                end
            end else if (!ras_n && !cas_n && !we_n) begin
                if (idle && !ba[1]) begin k = K_MRS; e_ext = ba[0]; end
                else il = 1'b1;
            end else begin
                if (idle) k = K_AREF;
                else il = 1'b1;
            end
        end
        m_ckep = cke;
        e_ill = il;
        e_strobe = (k == K_NONE) ? 14'b0 : (14'b1 << k);
        cur_tag = tag_of(k, il);
    endtask

    task automatic compare();
        logic [47:0] er;
        er = {m_rows[3], m_rows[2], m_rows[1], m_rows[0]};
        vectors++;
        if (strobe !== e_strobe || ill !== e_ill || bank !== e_bank || row !== e_row ||
            col !== e_col || ap !== e_ap || ext !== e_ext || act !== m_act ||
            rows !== er || lps !== 2'(m_lp)) begin
            fails++;
            $display("FAIL %s t=%0t actual strobe=%h ill=%b bank=%0d row=%h col=%h ap=%b ext=%b act=%b rows=%h lp=%0d expected strobe=%h ill=%b bank=%0d row=%h col=%h ap=%b ext=%b act=%b rows=%h lp=%0d",
                     cur_tag, $time, strobe, ill, bank, row, col, ap, ext, act, rows, lps,
                     e_strobe, e_ill, e_bank, e_row, e_col, e_ap, e_ext, m_act, er, m_lp);
        end
    endtask

    // Drive one cycle of pins, advance the model and check after the edge.
    task automatic apply(input bit k_e, input bit c, input bit [2:0] rcw,
                         input bit [1:0] b, input bit [11:0] a);
        cke = k_e; cs_n = c; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    localparam bit [2:0] P_NOP = 3'b111, P_ACT = 3'b011, P_PRE = 3'b010, P_RD = 3'b101,
                         P_WR = 3'b100, P_MRS = 3'b000, P_REF = 3'b001, P_BST = 3'b110;

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        compare();                                  // R12 reset state
        rst_n = 1'b1;
        apply(1, 0, P_NOP, 0, 12'h000);             // R2
        apply(1, 1, P_ACT, 2, 12'hFFF);             // R1 deselect ignores pins
        apply(1, 0, P_ACT, 1, 12'hABC);             // R3
        apply(1, 0, P_ACT, 1, 12'h123);             // R9 active bank
        apply(1, 0, P_RD,  1, 12'h035);             // R5 read
        apply(1, 0, P_WR,  2, 12'h011);             // R9 idle bank
        apply(1, 0, P_MRS, 0, 12'h032);             // R9 bank open
        apply(1, 0, P_BST, 3, 12'h000);             // R8
        apply(1, 0, P_REF, 0, 12'h000);             // R9 refresh with open bank
        apply(1, 0, P_PRE, 1, 12'h000);             // R4 single
        apply(1, 0, P_ACT, 0, 12'h5A5);             // R3
        apply(1, 0, P_ACT, 3, 12'h3C3);             // R3
        apply(1, 0, P_PRE, 2, 12'h100);             // R4 all
        apply(1, 0, P_MRS, 1, 12'h001);             // R6 extended
        apply(1, 0, P_MRS, 2, 12'h000);             // R9 BA1 high
        apply(1, 0, P_MRS, 0, 12'h032);             // R6 main
        apply(1, 0, P_REF, 0, 12'h000);             // R7
        apply(1, 0, P_ACT, 2, 12'h777);             // R3
        apply(1, 0, P_WR,  2, 12'h1FE);             // R5 auto-precharge closes
        apply(1, 0, P_RD,  2, 12'h000);             // R9 bank now idle
        apply(0, 0, P_REF, 0, 12'h000);             // R10 entry
        apply(0, 0, P_ACT, 1, 12'h111);             // R13 ignored
        apply(0, 1, P_NOP, 0, 12'h000);             // R13
        apply(1, 0, P_ACT, 1, 12'h222);             // R10 exit, pins ignored
        apply(1, 0, P_ACT, 0, 12'h444);             // R3
        apply(0, 0, P_NOP, 0, 12'h000);             // R11 active power-down
        apply(0, 0, P_PRE, 0, 12'h100);             // R13 ignored
        apply(1, 0, P_NOP, 0, 12'h000);             // R11 exit
        apply(1, 0, P_PRE, 0, 12'h000);             // R4
        apply(0, 1, P_NOP, 0, 12'h000);             // R11 precharge power-down
        apply(1, 0, P_NOP, 0, 12'h000);             // R11 exit
        apply(1, 0, P_ACT, 1, 12'h999);             // R3
        apply(0, 0, P_REF, 0, 12'h000);             // R9 refused self-refresh
        apply(0, 0, P_PRE, 1, 12'h000);             // R13 CKE low twice
        apply(1, 0, P_PRE, 1, 12'h000);             // R13 wake cycle ignored
        apply(1, 0, P_RD,  1, 12'h0AA);             // R5 bank still open
        for (int i = 0; i < 6000; i++) begin
            bit          kk;
            bit [2:0]    pat;
            kk  = (m_lp != 0) ? ($urandom_range(0, 2) == 0) : ($urandom_range(0, 15) != 0);
            pat = 3'($urandom);
            apply(kk, ($urandom_range(0, 9) == 0), pat, 2'($urandom), 12'($urandom));
        end
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            vectors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule